// File: doc/BRIEF.md
# Packed-BCD Calendar Timekeeper with Guarded Register Access

This core keeps wall-clock time and a calendar date in packed BCD. It is clocked directly from a 32.768 kHz source. A two-stage programmable divider turns that clock into a once-per-second pulse. The pulse advances seconds, minutes and hours, then the day of month, the month and a two-digit year, following real month lengths and leap years. The same pulse is driven out on `tick_1hz` for neighbouring blocks.

Software reaches the core over a small synchronous register bus in the same clock domain. The bus has six word registers:

| Offset | Register |
|--------|----------|
| 0 | unlock key |
| 1 | control |
| 2 | status |
| 3 | divider settings |
| 4 | time |
| 5 | date |

Every change to control or configuration is refused until a two-byte unlock sequence has been written to the key register. Loading a new time, date or divider setting needs one more step: software requests init mode, waits for the acknowledge flag, writes the values, then drops the request. Counting stays frozen from the moment init mode is requested until the acknowledge flag has fallen again.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the block reads as follows. It is locked. Control and status read 0. The divider register reads 0x007F_00FF. Time reads 0x0000_0000 (00:00:00) and date reads 0x0000_0101 (year 00, month 01, day 01). With the default divider the seconds count first advances after 32768 clocks.
- R2: The key register is at offset 0. It opens the block only when 0xCA is written to it and the very next bus write is 0x53 to the same register. Status bit 1 (status is at offset 2) reads 1 while the block is open. A write to any other register between the two key bytes cancels the sequence.
- R3: Any other value written to the key register, such as 0xFF, locks the block again. While the block is locked, writes to control (offset 1) are ignored.
- R4: Control bit 0 requests init mode. Status bit 0 (the acknowledge flag) rises two clocks after the control write that sets the request, and falls two clocks after the request is cleared.
- R5: While the init request or the acknowledge flag is set, the calendar does not advance. Time (offset 4) and date (offset 5) accept writes only while the block is open and the acknowledge flag is set. Writes at any other time are ignored.
- R6: The divider register is at offset 3. The synchronous setting S is in bits 14:0 and the asynchronous setting A in bits 22:16. One seconds pulse occurs every (A+1)*(S+1) clocks. The register accepts writes only while the block is open and the acknowledge flag is set.
- R7: `tick_1hz` is high for one clock in each divider period, and only while not in init mode. The seconds field advances on that clock.
- R8: The time word holds seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16. Seconds and minutes count 00 to 59 in BCD and carry into the next field when they wrap.
- R9: When control bit 1 is 0 (24-hour mode), hours count 00 to 23. The wrap from 23:59:59 to 00:00:00 advances the day.
- R10: When control bit 1 is 1 (12-hour mode), hours run 12, 01 … 11, and bit 22 of the time word marks PM. The step from 11 to 12 toggles PM. The step from 12 to 01 leaves PM unchanged. The step from 11 PM to 12 AM advances the day.
- R11: The date word holds the day in bits 5:0, the month in bits 12:8 and the year in bits 23:16. Day wraps to 01 after the last day of the month: 30 days for months 04, 06, 09 and 11; 31 days for the others; 29 days for month 02 when the year is divisible by 4 and 28 otherwise. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timekeeping clock, also the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_1hz | output | 1 | One-clock seconds pulse |

## Verification
On every clock, the assertions check four properties. The block opens only on a write of the second key byte. A key write of any other value leaves it locked. The acknowledge flag never rises without two cycles of request behind it. While frozen, the time word holds unless software writes it, and each seconds pulse happens outside init mode and changes the seconds field.

The bench scenarios cover the rest. They measure the exact divider period and the refusal of writes while locked or outside init mode. They also drive the calendar carries: the 24-hour and 12-hour hour sequences with the PM flag, month lengths, leap and non-leap February, and the year wrap. Each of these needs chosen start values and a comparison against independently computed results.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int unsigned BUS_AW = 3;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_KEY   = 3'd0;
  localparam logic [BUS_AW-1:0] OFS_CTRL  = 3'd1;
  localparam logic [BUS_AW-1:0] OFS_STAT  = 3'd2;
  localparam logic [BUS_AW-1:0] OFS_DIV   = 3'd3;
  localparam logic [BUS_AW-1:0] OFS_TIME  = 3'd4;
  localparam logic [BUS_AW-1:0] OFS_DATE  = 3'd5;

  localparam logic [7:0] UNLOCK_FIRST  = 8'hCA;
  localparam logic [7:0] UNLOCK_SECOND = 8'h53;

  typedef enum logic [1:0] {
    GUARD_SHUT = 2'd0,
    GUARD_HALF = 2'd1,
    GUARD_OPEN = 2'd2
  } guard_state_e;

  // Increment a two-digit packed BCD value (no range limit).
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last day of a BCD month; leap test done directly on the BCD year.
  function automatic logic [5:0] last_day(input logic [4:0] mon,
                                          input logic [7:0] yr);
    logic [5:0] mod_sum;
    mod_sum = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
    case (mon)
      5'h02:                      return (mod_sum[1:0] == 2'b00) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_key_guard.sv
module rtc_key_guard
  import bcd_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_any,
  input  logic       wr_key,
  input  logic [7:0] key_byte,
  output logic       unlocked
);

  guard_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_key) begin
      if (state_q == GUARD_HALF && key_byte == UNLOCK_SECOND) state_d = GUARD_OPEN;
      else if (key_byte == UNLOCK_FIRST)                      state_d = GUARD_HALF;
      else                                                    state_d = GUARD_SHUT;
    end else if (wr_any && state_q == GUARD_HALF) begin
      state_d = GUARD_SHUT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GUARD_SHUT;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == GUARD_OPEN);

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned AW = 7,
  parameter int unsigned SW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW-1:0] async_lim,
  input  logic [SW-1:0] sync_lim,
  output logic          sec_pulse
);

  logic [AW-1:0] a_q, a_d;
  logic [SW-1:0] s_q, s_d;
  logic          a_wrap, s_wrap;

  assign a_wrap    = (a_q == async_lim);
  assign s_wrap    = (s_q == sync_lim);
  assign sec_pulse = run & a_wrap & s_wrap;

  always_comb begin
    a_d = a_q;
    s_d = s_q;
    if (!run) begin
      a_d = '0;
      s_d = '0;
    end else if (a_wrap) begin
      a_d = '0;
      s_d = s_wrap ? '0 : s_q + 1'b1;
    end else begin
      a_d = a_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      s_q <= '0;
    end else begin
      a_q <= a_d;
      s_q <= s_d;
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        hour12,
  input  logic        ld_time,
  input  logic        ld_date,
  input  logic [31:0] wdata,
  output logic [31:0] time_word,
  output logic [31:0] date_word
);

  logic [6:0] sec_q, sec_d, min_q, min_d;
  logic [5:0] hr_q, hr_d, day_q, day_d;
  logic [4:0] mon_q, mon_d;
  logic [7:0] yr_q, yr_d;
  logic       pm_q, pm_d;

  logic [7:0] sec_inc, min_inc, hr_inc, day_inc, mon_inc, yr_inc;
  logic [5:0] day_max;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  assign sec_inc = bcd_step({1'b0, sec_q});
  assign min_inc = bcd_step({1'b0, min_q});
  assign hr_inc  = bcd_step({2'b00, hr_q});
  assign day_inc = bcd_step({2'b00, day_q});
  assign mon_inc = bcd_step({3'b000, mon_q});
  assign yr_inc  = bcd_step(yr_q);
  assign day_max = last_day(mon_q, yr_q);

  always_comb begin
    sec_d = sec_q; min_d = min_q; hr_d = hr_q; pm_d = pm_q;
    day_d = day_q; mon_d = mon_q; yr_d = yr_q;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;

    if (tick) begin
      if (sec_q == 7'h59) begin sec_d = '0; c_min = 1'b1; end
      else                       sec_d = sec_inc[6:0];
    end
    if (c_min) begin
      if (min_q == 7'h59) begin min_d = '0; c_hr = 1'b1; end
      else                       min_d = min_inc[6:0];
    end
    if (c_hr) begin
      if (!hour12) begin
        if (hr_q == 6'h23) begin hr_d = '0; c_day = 1'b1; end
        else                      hr_d = hr_inc[5:0];
      end else if (hr_q == 6'h12) begin
        hr_d = 6'h01;
      end else if (hr_q == 6'h11) begin
        hr_d  = 6'h12;
        pm_d  = ~pm_q;
        c_day = pm_q;
      end else begin
        hr_d = hr_inc[5:0];
      end
    end
    if (c_day) begin
      if (day_q == day_max) begin day_d = 6'h01; c_mon = 1'b1; end
      else                         day_d = day_inc[5:0];
    end
    if (c_mon) begin
      if (mon_q == 5'h12) begin mon_d = 5'h01; c_yr = 1'b1; end
      else                       mon_d = mon_inc[4:0];
    end
    if (c_yr) begin
      yr_d = (yr_q == 8'h99) ? 8'h00 : yr_inc;
    end

    if (ld_time) begin
      sec_d = wdata[6:0];
      min_d = wdata[14:8];
      hr_d  = wdata[21:16];
      pm_d  = wdata[22];
    end
    if (ld_date) begin
      day_d = wdata[5:0];
      mon_d = wdata[12:8];
      yr_d  = wdata[23:16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hr_q <= '0; pm_q <= 1'b0;
      day_q <= 6'h01; mon_q <= 5'h01; yr_q <= 8'h00;
    end else begin
      sec_q <= sec_d; min_q <= min_d; hr_q <= hr_d; pm_q <= pm_d;
      day_q <= day_d; mon_q <= mon_d; yr_q <= yr_d;
    end
  end

  assign time_word = {9'b0, pm_q, hr_q, 1'b0, min_q, 1'b0, sec_q};
  assign date_word = {8'b0, yr_q, 3'b0, mon_q, 2'b0, day_q};

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned ASYNC_W     = 7,
  parameter int unsigned SYNC_W      = 15,
  parameter int unsigned ACK_STAGES  = 2,
  parameter logic [ASYNC_W-1:0] ASYNC_DEF = 7'h7F,
  parameter logic [SYNC_W-1:0]  SYNC_DEF  = 15'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              tick_1hz
);

  localparam int unsigned ASYNC_LSB = 16;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // write decode
  logic unlocked, initf;
  logic wr_key, wr_ctrl, wr_div, ld_time, ld_date;

  assign wr_key  = bus_wr && (bus_addr == OFS_KEY);
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL) && unlocked;
  assign wr_div  = bus_wr && (bus_addr == OFS_DIV)  && unlocked && initf;
  assign ld_time = bus_wr && (bus_addr == OFS_TIME) && unlocked && initf;
  assign ld_date = bus_wr && (bus_addr == OFS_DATE) && unlocked && initf;

  rtc_key_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_any   (bus_wr),
    .wr_key   (wr_key),
    .key_byte (bus_wdata[7:0]),
    .unlocked (unlocked)
  );

  // control and divider registers
  logic               init_req_q, init_req_d;
  logic               hour12_q, hour12_d;
  logic [ASYNC_W-1:0] div_a_q, div_a_d;
  logic [SYNC_W-1:0]  div_s_q, div_s_d;

  always_comb begin
    init_req_d = init_req_q;
    hour12_d   = hour12_q;
    div_a_d    = div_a_q;
    div_s_d    = div_s_q;
    if (wr_ctrl) begin
      init_req_d = bus_wdata[0];
      hour12_d   = bus_wdata[1];
    end
    if (wr_div) begin
      div_s_d = bus_wdata[SYNC_W-1:0];
      div_a_d = bus_wdata[ASYNC_LSB +: ASYNC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      init_req_q <= 1'b0;
      hour12_q   <= 1'b0;
      div_a_q    <= ASYNC_DEF;
      div_s_q    <= SYNC_DEF;
    end else begin
      init_req_q <= init_req_d;
      hour12_q   <= hour12_d;
      div_a_q    <= div_a_d;
      div_s_q    <= div_s_d;
    end
  end

  // init acknowledge: request carried through ACK_STAGES flops
  logic [ACK_STAGES-1:0] ack_pipe;

  generate
    if (ACK_STAGES == 1) begin : g_ack_one
      always_ff @(posedge clk or negedge rst_core_n) begin
        if (!rst_core_n) ack_pipe <= '0;
        else             ack_pipe <= init_req_q;
      end
    end else begin : g_ack_many
      always_ff @(posedge clk or negedge rst_core_n) begin
        if (!rst_core_n) ack_pipe <= '0;
        else             ack_pipe <= {ack_pipe[ACK_STAGES-2:0], init_req_q};
      end
    end
  endgenerate

  assign initf = ack_pipe[ACK_STAGES-1];

  // divider and calendar
  logic        run;
  logic [31:0] time_word, date_word;

  assign run = ~init_req_q & ~initf;

  rtc_prescaler #(.AW(ASYNC_W), .SW(SYNC_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (run),
    .async_lim (div_a_q),
    .sync_lim  (div_s_q),
    .sec_pulse (tick_1hz)
  );

  rtc_calendar u_cal (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick      (tick_1hz),
    .hour12    (hour12_q),
    .ld_time   (ld_time),
    .ld_date   (ld_date),
    .wdata     (bus_wdata),
    .time_word (time_word),
    .date_word (date_word)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: bus_rdata[1:0] = {hour12_q, init_req_q};
      OFS_STAT: bus_rdata[1:0] = {unlocked, initf};
      OFS_DIV: begin
        bus_rdata[SYNC_W-1:0]         = div_s_q;
        bus_rdata[ASYNC_LSB +: ASYNC_W] = div_a_q;
      end
      OFS_TIME: bus_rdata = time_word;
      OFS_DATE: bus_rdata = date_word;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/bcd_timekeeper_chk.sv
module bcd_timekeeper_chk
  import bcd_rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_core_n,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic              unlocked,
  input logic              init_req,
  input logic              initf,
  input logic              tick,
  input logic [31:0]       time_word
);

  assert_open_on_second_key_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(unlocked) |-> $past(bus_wr && bus_addr == OFS_KEY && bus_wdata[7:0] == UNLOCK_SECOND));

  assert_other_key_locks_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wr && bus_addr == OFS_KEY && bus_wdata[7:0] != UNLOCK_SECOND) |=> !unlocked);

  assert_ack_after_two_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(initf) |-> ($past(init_req) && $past(init_req, 2)));

  assert_frozen_time_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((init_req || initf) && !(bus_wr && bus_addr == OFS_TIME)) |=> $stable(time_word));

  assert_tick_outside_init_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    tick |-> (!init_req && !initf));

  assert_tick_moves_seconds_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    tick |=> (time_word[6:0] != $past(time_word[6:0])));

endmodule

bind bcd_timekeeper bcd_timekeeper_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .unlocked   (unlocked),
  .init_req   (init_req_q),
  .initf      (initf),
  .tick       (tick_1hz),
  .time_word  (time_word)
);

// File: tb/bcd_timekeeper_test.sv
module bcd_timekeeper_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tick_1hz;

  int n_tests = 0;
  int n_fail  = 0;

  bcd_timekeeper uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_1hz  (tick_1hz)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        fmt12;
    logic [31:0] t_in;
    logic [31:0] d_in;
    logic [31:0] t_exp;
    logic [31:0] d_exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_0009, 32'h0025_0315, 32'h0000_0010, 32'h0025_0315}, // R8
    '{1'b0, 32'h0012_3459, 32'h0025_0315, 32'h0012_3500, 32'h0025_0315}, // R8
    '{1'b0, 32'h0013_5959, 32'h0025_0315, 32'h0014_0000, 32'h0025_0315}, // R8
    '{1'b0, 32'h0023_5959, 32'h0025_0315, 32'h0000_0000, 32'h0025_0316}, // R9
    '{1'b0, 32'h0023_5959, 32'h0024_0228, 32'h0000_0000, 32'h0024_0229}, // R11
    '{1'b0, 32'h0023_5959, 32'h0024_0229, 32'h0000_0000, 32'h0024_0301}, // R11
    '{1'b0, 32'h0023_5959, 32'h0023_0228, 32'h0000_0000, 32'h0023_0301}, // R11
    '{1'b0, 32'h0023_5959, 32'h0025_0430, 32'h0000_0000, 32'h0025_0501}, // R11
    '{1'b0, 32'h0023_5959, 32'h0025_1231, 32'h0000_0000, 32'h0026_0101}, // R11
    '{1'b0, 32'h0023_5959, 32'h0099_1231, 32'h0000_0000, 32'h0000_0101}, // R11
    '{1'b0, 32'h0023_5959, 32'h0025_0130, 32'h0000_0000, 32'h0025_0131}, // R11
    '{1'b1, 32'h0011_5959, 32'h0025_0315, 32'h0052_0000, 32'h0025_0315}, // R10
    '{1'b1, 32'h0052_5959, 32'h0025_0315, 32'h0041_0000, 32'h0025_0315}, // R10
    '{1'b1, 32'h0051_5959, 32'h0025_0315, 32'h0012_0000, 32'h0025_0316}, // R10
    '{1'b1, 32'h0012_5959, 32'h0025_0315, 32'h0001_0000, 32'h0025_0315}  // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic unlock();
    bus_write(3'd0, 32'h0000_00CA);
    bus_write(3'd0, 32'h0000_0053);
  endtask

  task automatic wait_ack(input string req);
    logic [31:0] st;
    logic        seen;
    seen = 1'b0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      bus_read(3'd2, st);
      seen = st[0];
    end
    check(req, {31'b0, seen}, 32'd1);
  endtask

  task automatic wait_tick(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!tick_1hz && cycles < 200);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          cyc, tick_seen;

    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(3'd1, rd); check("R1 ctrl", rd, 32'h0);
    bus_read(3'd2, rd); check("R1 status", rd, 32'h0);
    bus_read(3'd3, rd); check("R1 divider", rd, 32'h007F_00FF);
    bus_read(3'd4, rd); check("R1 time", rd, 32'h0);
    bus_read(3'd5, rd); check("R1 date", rd, 32'h0000_0101);
    check("R1 tick", {31'b0, tick_1hz}, 32'h0);

    // R1/R6 default divider: first second after 32768 clocks
    repeat (32700) @(negedge clk);
    bus_read(3'd4, rd); check("R1 no second yet", rd, 32'h0);
    repeat (100) @(negedge clk);
    bus_read(3'd4, rd); check("R1 one second", rd, 32'h0000_0001);

    // R3 locked: control write ignored
    bus_write(3'd1, 32'h1);
    bus_read(3'd1, rd); check("R3 ctrl while locked", rd, 32'h0);

    // R2 unlock
    unlock();
    bus_read(3'd2, rd); check("R2 unlocked", rd, 32'h2);
    // R3 relock with 0xFF
    bus_write(3'd0, 32'hFF);
    bus_read(3'd2, rd); check("R3 relocked", rd, 32'h0);
    // R2 sequence broken by another write
    bus_write(3'd0, 32'hCA);
    bus_write(3'd1, 32'h0);
    bus_write(3'd0, 32'h53);
    bus_read(3'd2, rd); check("R2 broken sequence", rd, 32'h0);

    unlock();
    // R5 time write outside init ignored; R6 divider write outside init ignored
    bus_write(3'd4, 32'h0012_3456);
    bus_read(3'd4, rd); check("R5 time outside init", rd, 32'h0000_0001);
    bus_write(3'd3, 32'h0002_0003);
    bus_read(3'd3, rd); check("R6 divider outside init", rd, 32'h007F_00FF);

    // R4 acknowledge timing
    bus_write(3'd1, 32'h1);
    bus_read(3'd2, rd); check("R4 ack +0", rd, 32'h2);
    @(negedge clk);
    bus_read(3'd2, rd); check("R4 ack +1", rd, 32'h2);
    @(negedge clk);
    bus_read(3'd2, rd); check("R4 ack +2", rd, 32'h3);

    // R6 divider write in init, R5 loads in init
    bus_write(3'd3, 32'h0002_0003);
    bus_read(3'd3, rd); check("R6 divider in init", rd, 32'h0002_0003);
    bus_write(3'd4, 32'h0000_0000);
    bus_write(3'd5, 32'h0025_0315);
    bus_read(3'd4, rd); check("R5 time load", rd, 32'h0);
    bus_read(3'd5, rd); check("R5 date load", rd, 32'h0025_0315);

    // R5 frozen while in init
    tick_seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick_1hz) tick_seen++;
    end
    check("R5 no tick in init", tick_seen, 0);
    bus_read(3'd4, rd); check("R5 time frozen", rd, 32'h0);

    // R4 acknowledge falls two clocks after clear
    bus_write(3'd1, 32'h0);
    @(negedge clk);
    bus_read(3'd2, rd); check("R4 ack still high", rd, 32'h3);
    @(negedge clk);
    bus_read(3'd2, rd); check("R4 ack cleared", rd, 32'h2);

    // R6 period (2+1)*(3+1)=12, R7 seconds advance per pulse
    wait_tick(cyc);
    wait_tick(cyc);
    check("R6 period", cyc, 12);
    @(negedge clk);
    check("R7 pulse one clock", {31'b0, tick_1hz}, 32'h0);
    bus_read(3'd4, rd); check("R7 seconds after two pulses", rd, 32'h0000_0002);

    // table walk: divider period 4
    bus_write(3'd1, 32'h1);
    wait_ack("R4 ack for table");
    bus_write(3'd3, 32'h0001_0001);
    for (int v = 0; v < NV; v++) begin
      bus_write(3'd1, {30'b0, VECS[v].fmt12, 1'b1});
      wait_ack("R4 ack per vector");
      bus_write(3'd4, VECS[v].t_in);
      bus_write(3'd5, VECS[v].d_in);
      bus_write(3'd1, {30'b0, VECS[v].fmt12, 1'b0});
      wait_tick(cyc);
      @(negedge clk);
      bus_read(3'd4, rd);
      check($sformatf("R8-R10 time vector %0d", v), rd, VECS[v].t_exp);
      bus_read(3'd5, rd);
      check($sformatf("R9/R11 date vector %0d", v), rd, VECS[v].d_exp);
    end

    summary();
    $finish;
  end

endmodule